// File: doc/BRIEF.md
# Polyphase Parallel Ramp Sample Generator

This block produces a stream of ramp samples for a high-rate DAC without running any counter at the sample rate. On each cycle of a slow fabric clock it computes several consecutive ramp samples in parallel and packs them into one wide word. A downstream serializer or DDR output stage sends the lanes of that word out one after another at the lane count times the fabric rate. With the default five lanes of 8 bits, a 100 MHz fabric clock therefore yields 500 Msamples/s.

A base register holds the value of the first sample of the next word. Lane k adds k times the programmed step to that base, so the lanes are staggered copies one step apart rather than duplicates. Each enabled cycle the base advances by the lane count times the step. Read in lane order and then word after word, the samples form one unbroken ramp that wraps modulo 256. A parameter selects whether the lane offsets come from one small multiply per lane or from a chain of adders.

Top module: `polyphase_ramp_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `lane_word` equal to zero and `word_valid` low.
- R2: `word_valid` stays low after reset until the first clock edge with `en` high and `rst` low, is high from the next cycle on, and stays high until the next reset.
- R3: On the n-th enabled clock edge after reset (n counted from 0), the word registered holds in lane k the value (5n + k)·S mod 256, S being `step`; lane k occupies bits [8k+7:8k], so lane 0 is the least significant byte and leaves the serializer first.
- R4: Read serially (lane 0 to lane 4 of one word, then lane 0 of the next word), each sample equals the previous sample plus S modulo 256, both inside a word and across word boundaries.
- R5: A clock edge with `en` low and `rst` low leaves `lane_word` and `word_valid` unchanged, and the ramp resumes where it stopped when `en` returns high.
- R6: Wraparound past 255 happens inside a word: with S = 1 the word from enabled edge n = 51 reads, lane 0 to lane 4, 255, 0, 1, 2, 3 (packed value 40'h03020100FF).
- R7: The output word is registered: the lanes change only on the clock edge where `en` is high, one register stage after the base value they are built from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the ramp and load a new word |
| step | input | SAMPLE_W (8) | Increment between successive serial samples |
| lane_word | output | LANES*SAMPLE_W (40) | Packed lanes, lane 0 in the low byte |
| word_valid | output | 1 | High once a word has been produced since reset |

## Verification
Every step value from 0 to 255 is run from reset for about sixty words, so the step is swept exhaustively: step 0 tells a flat output from a stuck base, odd steps expose lanes using the wrong multiple of the step, and even steps such as 128 catch carries that should fall off the 8-bit edge. Each word is compared lane by lane with (5n + k)·S computed in the bench, and a serial unpacker checks that each sample exceeds its predecessor by S, which separates a wrong lane order from a wrong base stride. For some steps enable is dropped for three cycles mid-run, which shows whether the held word repeats and whether the ramp resumes without skipping a word; step 1 at word 51 pins the wrap inside a word.

// File: rtl/polyramp_pkg.sv
package polyramp_pkg;

   // Default geometry: five lanes of eight bits
   localparam int unsigned DEF_LANES    = 5;
   localparam int unsigned DEF_SAMPLE_W = 8;

   // How the per-lane offsets are formed
   typedef enum logic {
      LANE_MULT  = 1'b0,   // offset k*step, one small multiply per lane
      LANE_CHAIN = 1'b1    // offset built by adding step lane after lane
   } lane_mode_e;

endpackage

// File: rtl/prm_base_acc.sv
module prm_base_acc #(
   parameter int unsigned LANES    = polyramp_pkg::DEF_LANES,
   parameter int unsigned SAMPLE_W = polyramp_pkg::DEF_SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                adv,
   input  logic [SAMPLE_W-1:0] step,
   output logic [SAMPLE_W-1:0] base
);

   localparam logic [SAMPLE_W-1:0] LANES_W = SAMPLE_W'(LANES);

   logic [SAMPLE_W-1:0] stride;

   // One word covers LANES samples, so the base jumps LANES steps
   assign stride = step * LANES_W;

   always_ff @(posedge clk) begin
      if (rst) begin
         base <= '0;
      end else if (adv) begin
         base <= base + stride;
      end
   end

endmodule

// File: rtl/prm_lane_calc.sv
module prm_lane_calc
   import polyramp_pkg::*;
#(
   parameter int unsigned LANES     = DEF_LANES,
   parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
   parameter lane_mode_e  LANE_MODE = LANE_MULT
) (
   input  logic [SAMPLE_W-1:0]       base,
   input  logic [SAMPLE_W-1:0]       step,
   output logic [LANES*SAMPLE_W-1:0] lanes
);

   logic [SAMPLE_W-1:0] lane_v [LANES];

   generate
      if (LANE_MODE == LANE_MULT) begin : g_mult
         for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [SAMPLE_W-1:0] offs;
            assign offs      = step * SAMPLE_W'(k);
            assign lane_v[k] = base + offs;
         end
      end else begin : g_chain
         assign lane_v[0] = base;
         for (genvar k = 1; k < LANES; k++) begin : g_lane
            assign lane_v[k] = lane_v[k-1] + step;
         end
      end

      for (genvar k = 0; k < LANES; k++) begin : g_pack
         assign lanes[k*SAMPLE_W +: SAMPLE_W] = lane_v[k];
      end
   endgenerate

endmodule

// File: rtl/prm_out_reg.sv
module prm_out_reg #(
   parameter int unsigned LANES    = polyramp_pkg::DEF_LANES,
   parameter int unsigned SAMPLE_W = polyramp_pkg::DEF_SAMPLE_W
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      load,
   input  logic [LANES*SAMPLE_W-1:0] lanes_d,
   output logic [LANES*SAMPLE_W-1:0] lanes_q,
   output logic                      valid_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         lanes_q <= '0;
         valid_q <= 1'b0;
      end else if (load) begin
         lanes_q <= lanes_d;
         valid_q <= 1'b1;
      end
   end

endmodule

// File: rtl/polyphase_ramp_gen.sv
module polyphase_ramp_gen
   import polyramp_pkg::*;
#(
   parameter int unsigned LANES     = DEF_LANES,
   parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
   parameter lane_mode_e  LANE_MODE = LANE_MULT
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en,
   input  logic [SAMPLE_W-1:0]       step,
   output logic [LANES*SAMPLE_W-1:0] lane_word,
   output logic                      word_valid
);

   localparam int unsigned WORD_W = LANES * SAMPLE_W;

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("polyphase_ramp_gen: LANES must be at least 2");
      end
      if (SAMPLE_W < 2 || SAMPLE_W > 16) begin : g_bad_width
         $error("polyphase_ramp_gen: SAMPLE_W must lie in 2..16");
      end
      if (LANES >= (1 << SAMPLE_W)) begin : g_bad_ratio
         $error("polyphase_ramp_gen: LANES must be below 2**SAMPLE_W");
      end
   endgenerate

   logic [SAMPLE_W-1:0] base;
   logic [WORD_W-1:0]   lanes_comb;

   prm_base_acc #(
      .LANES    (LANES),
      .SAMPLE_W (SAMPLE_W)
   ) u_base (
      .clk  (clk),
      .rst  (rst),
      .adv  (en),
      .step (step),
      .base (base)
   );

   prm_lane_calc #(
      .LANES     (LANES),
      .SAMPLE_W  (SAMPLE_W),
      .LANE_MODE (LANE_MODE)
   ) u_calc (
      .base  (base),
      .step  (step),
      .lanes (lanes_comb)
   );

   prm_out_reg #(
      .LANES    (LANES),
      .SAMPLE_W (SAMPLE_W)
   ) u_oreg (
      .clk     (clk),
      .rst     (rst),
      .load    (en),
      .lanes_d (lanes_comb),
      .lanes_q (lane_word),
      .valid_q (word_valid)
   );

endmodule

// File: rtl/prm_checker.sv
module prm_checker #(
   parameter int unsigned LANES = 5,
   parameter int unsigned SW    = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                en,
   input logic [SW-1:0]       step,
   input logic [LANES*SW-1:0] lane_word,
   input logic                word_valid
);

   logic [SW-1:0] last_step;
   logic [SW-1:0] first_lane;
   logic [SW-1:0] final_lane;

   assign first_lane = lane_word[SW-1:0];
   assign final_lane = lane_word[(LANES-1)*SW +: SW];

   // Step that built the word currently on the output
   always_ff @(posedge clk) begin
      if (rst)     last_step <= '0;
      else if (en) last_step <= step;
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (lane_word == '0) && !word_valid); // R1

   AST_VALID_ON_EN: assert property (@(posedge clk) disable iff (rst)
      en |=> word_valid); // R2

   AST_VALID_STAYS: assert property (@(posedge clk) disable iff (rst)
      word_valid |=> word_valid); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(lane_word) && $stable(word_valid)); // R5

   AST_SEAM_STEP: assert property (@(posedge clk) disable iff (rst)
      (en && word_valid) |=>
         (first_lane == SW'($past(final_lane) + $past(last_step)))); // R4

   generate
      for (genvar k = 0; k + 1 < LANES; k++) begin : g_spacing
         logic [SW-1:0] gap;
         assign gap = lane_word[(k+1)*SW +: SW] - lane_word[k*SW +: SW];
         AST_LANE_SPACING: assert property (@(posedge clk) disable iff (rst)
            en |=> (gap == $past(step))); // R3
      end
   endgenerate

endmodule

bind polyphase_ramp_gen prm_checker #(
   .LANES (LANES),
   .SW    (SAMPLE_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .en         (en),
   .step       (step),
   .lane_word  (lane_word),
   .word_valid (word_valid)
);

// File: tb/polyphase_ramp_gen_test.sv
module polyphase_ramp_gen_test;

   localparam int NL = 5;
   localparam int SW = 8;
   localparam int RUN_CYCLES = 60;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en  = 1'b0;
   logic [SW-1:0] step = '0;
   logic [NL*SW-1:0] lane_word;
   logic          word_valid;

   int n_cmp  = 0;
   int n_bad  = 0;
   int cycles = 0;
   bit done   = 0;

   polyphase_ramp_gen uut (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .step       (step),
      .lane_word  (lane_word),
      .word_valid (word_valid)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      while (!done && cycles < 150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #1;
      for (int s = 0; s < 256; s++) begin
         int n;
         int prev;
         bit have_prev;
         bit hold_run;
         logic [NL*SW-1:0] held;

         step = SW'(s);
         rst  = 1'b1;
         en   = 1'b0;
         tick();
         tick();
         chk("R1 word", 64'(lane_word), 64'd0);
         chk("R1 valid", 64'(word_valid), 64'd0);

         rst = 1'b0;
         tick();
         chk("R2 idle valid", 64'(word_valid), 64'd0);
         chk("R5 idle word", 64'(lane_word), 64'd0);

         n         = 0;
         prev      = 0;
         have_prev = 0;
         hold_run  = (s % 16 == 3);
         held      = lane_word;
         for (int c = 0; c < RUN_CYCLES; c++) begin
            bit go;
            go = !(hold_run && c >= 20 && c <= 22);
            en = go;
            tick();
            if (go) begin
               chk("R2 valid", 64'(word_valid), 64'd1);
               for (int k = 0; k < NL; k++) begin
                  int exp_v;
                  int act_v;
                  exp_v = ((NL * n + k) * s) % 256;
                  act_v = int'(lane_word[k*SW +: SW]);
                  chk("R3 R7 lane", 64'(act_v), 64'(exp_v));
                  // serial unpacker: lane 0 first, then next lanes
                  if (have_prev)
                     chk("R4 serial", 64'(act_v), 64'((prev + s) % 256));
                  prev      = act_v;
                  have_prev = 1;
               end
               if (s == 1 && n == 51)
                  chk("R6 wrap", 64'(lane_word), 64'h03020100FF);
               n++;
               held = lane_word;
            end else begin
               chk("R5 hold word", 64'(lane_word), 64'(held));
               chk("R5 hold valid", 64'(word_valid), 64'd1);
            end
         end
         en = 1'b0;
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule